// File: doc/BRIEF.md
# Stipple and Block-Copy Raster Engine

This block is a small drawing accelerator for an 8-bit-per-pixel frame buffer. It sits behind a 32-bit register window and drives a synchronous pixel memory port. Each command takes two writes. The first write stores a colour word. The second write carries the destination pixel in its bus address and starts the operation. A window-select input picks one of two operation kinds.

In the stipple window, the 32-bit trigger data is a mask. Every set bit paints one pixel with the stored colour. In the blit window, the trigger data gives a run length and a source pixel address. A reserved source value turns the copy into a solid fill. The engine handles one pixel per cycle and holds a busy flag while it works. A second trigger that arrives during an operation is held off through the bus ready signal. When an operation ends, the engine reports the pixel range it touched so that the display refresh logic can redraw that range.

Top module: `raster_engine`

## Requirements
- R1: A full-word write with bus address bit 2 clear stores the data as the colour word. It causes no pixel memory access. Later operations use bits 7:0 of the colour word.
- R2: A full-word write with bus address bit 2 set starts an operation. Its destination pixel is bus address bits 22:3. Address bits 1:0 are ignored.
- R3: In stipple mode (`win_blit`=0) the operation takes 32 cycles. In step k it writes destination+k only when mask bit 31-k is 1, so bit 31 maps to +0 and bit 0 maps to +31.
- R4: In blit mode (`win_blit`=1) the run length is trigger data bits 28:24 plus one, from 1 to 32 pixels.
- R5: When blit source field bits 23:0 are all ones, the run is filled with the colour byte, one pixel per cycle.
- R6: Any other blit source value copies the run in ascending order. Each pixel is read from the source in one cycle and written to the destination in the next cycle. A forward overlapping copy therefore spreads the first byte, as a byte-by-byte copy does. Reads and writes never occur in the same cycle.
- R7: Reads of either window return zero and have no side effect.
- R8: Writes whose byte enables are not all four set are ignored, both as colour writes and as triggers.
- R9: `busy` rises in the cycle after a trigger is accepted and falls after the last pixel. While `busy` is high, a trigger write sees `bus_ready` low and is held. A colour write during an operation is accepted and does not change the running operation.
- R10: In the cycle after the last pixel, `dirty_valid` pulses for one cycle. `dirty_start` gives the destination pixel and `dirty_len` gives the run length (32 for stipple).
- R11: After reset `busy`, `dirty_valid`, `mem_we` and `mem_re` are low, `bus_ready` is high and the colour word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (23) | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| win_blit | input | 1 | 0 = stipple window, 1 = blit window |
| bus_rdata | output | 32 | Read data, always zero |
| bus_ready | output | 1 | Low while a trigger write is held |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 24 | Pixel address |
| mem_we | output | 1 | Pixel write strobe |
| mem_wdata | output | 8 | Pixel write data |
| mem_re | output | 1 | Pixel read strobe; data arrives one cycle later |
| mem_rdata | input | 8 | Pixel read data |
| dirty_valid | output | 1 | One-cycle pulse at the end of an operation |
| dirty_start | output | 24 | First pixel touched |
| dirty_len | output | 6 | Number of pixels in the range |

## Verification
The assertions assume that the pixel memory answers a read strobe with data in the next cycle. They also assume that a bus request stays asserted until `bus_ready` is seen high. The bench models a memory with exactly that one-cycle latency. Its bus tasks hold each request across stalled cycles and release it only after the accepting clock edge. The stimulus avoids partial accesses, except in the cases that check that such accesses are ignored.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int PIX_AW  = 24;
  localparam int RUN_MAX = 32;
  localparam int LEN_W   = $clog2(RUN_MAX) + 1;
  localparam int DST_W   = 20;

  typedef enum logic [1:0] {OP_STIP, OP_FILL, OP_COPY} op_kind_e;

  typedef struct packed {
    op_kind_e            kind;
    logic [PIX_AW-1:0]   dst;
    logic [PIX_AW-1:0]   src;
    logic [LEN_W-1:0]    len;
    logic [31:0]         mask;
    logic [7:0]          colour;
  } op_t;

  // destination pixel carried in the bus address (byte address / 8)
  function automatic logic [PIX_AW-1:0] dst_pix(input logic [DST_W+2:0] a);
    return {{(PIX_AW-DST_W){1'b0}}, a[DST_W+2:3]};
  endfunction

  function automatic logic [LEN_W-1:0] blit_len(input logic [4:0] f);
    return {1'b0, f} + LEN_W'(1);
  endfunction

  function automatic logic src_is_fill(input logic [PIX_AW-1:0] s);
    return &s;
  endfunction

  // step k paints when mask bit (31-k) is set
  function automatic logic stip_hit(input logic [31:0] m, input logic [4:0] k);
    return m[5'd31 - k];
  endfunction
endpackage

// File: rtl/raster_cmd.sv
module raster_cmd
  import raster_pkg::*;
#(
  parameter int BUS_AW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              win_blit,
  input  logic              busy,
  output logic              bus_ready,
  output logic              op_start,
  output op_t               op
);
  logic [31:0] colour_q;
  logic        wr_ok, is_trig;
  logic        unused_bits;

  assign wr_ok   = bus_sel && bus_wr && (bus_be == 4'hF);
  assign is_trig = bus_addr[2];
  assign unused_bits = ^{bus_addr[1:0], colour_q[31:8], bus_wdata[31:29]};

  always_ff @(posedge clk) begin
    if (!rst_n) colour_q <= '0;
    else if (wr_ok && !is_trig) colour_q <= bus_wdata;
  end

  assign bus_ready = !(busy && bus_sel && bus_wr && is_trig);
  assign op_start  = wr_ok && is_trig && !busy;

  always_comb begin
    op.dst    = dst_pix(bus_addr[DST_W+2:0]);
    op.src    = bus_wdata[PIX_AW-1:0];
    op.mask   = bus_wdata;
    op.colour = colour_q[7:0];
    if (win_blit) begin
      op.kind = src_is_fill(bus_wdata[PIX_AW-1:0]) ? OP_FILL : OP_COPY;
      op.len  = blit_len(bus_wdata[28:24]);
    end else begin
      op.kind = OP_STIP;
      op.len  = LEN_W'(RUN_MAX);
    end
  end
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  op_t               op_in,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              op_done,
  output logic [PIX_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  output logic              dirty_valid,
  output logic [PIX_AW-1:0] dirty_start,
  output logic [LEN_W-1:0]  dirty_len
);
  op_t              op_q;
  logic             run_q, ph_q, last;
  logic [LEN_W-1:0] idx_q;
  logic [PIX_AW-1:0] off;

  assign off     = PIX_AW'(idx_q);
  assign last    = (idx_q == op_q.len - LEN_W'(1)) && (op_q.kind != OP_COPY || ph_q);
  assign op_done = run_q && last;
  assign busy    = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; ph_q <= 1'b0; idx_q <= '0; op_q <= '0;
      dirty_valid <= 1'b0; dirty_start <= '0; dirty_len <= '0;
    end else begin
      dirty_valid <= op_done;
      if (op_done) begin
        dirty_start <= op_q.dst;
        dirty_len   <= op_q.len;
      end
      if (op_start) begin
        run_q <= 1'b1; op_q <= op_in; idx_q <= '0; ph_q <= 1'b0;
      end else if (run_q) begin
        if (op_q.kind == OP_COPY) begin
          ph_q <= ~ph_q;
          if (ph_q) idx_q <= idx_q + LEN_W'(1);
        end else begin
          idx_q <= idx_q + LEN_W'(1);
        end
        if (last) run_q <= 1'b0;
      end
    end
  end

  always_comb begin
    mem_addr  = op_q.dst + off;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = op_q.colour;
    unique case (op_q.kind)
      OP_STIP: mem_we = run_q && stip_hit(op_q.mask, idx_q[4:0]);
      OP_FILL: mem_we = run_q;
      OP_COPY: begin
        mem_re    = run_q && !ph_q;
        mem_we    = run_q && ph_q;
        mem_wdata = mem_rdata;
        if (!ph_q) mem_addr = op_q.src + off;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/raster_engine.sv
module raster_engine
  import raster_pkg::*;
#(
  parameter int BUS_AW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              win_blit,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              busy,
  output logic [23:0]       mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              dirty_valid,
  output logic [23:0]       dirty_start,
  output logic [5:0]        dirty_len
);
  op_t  op;
  logic op_start, op_done;

  assign bus_rdata = '0;

  raster_cmd #(.BUS_AW(BUS_AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .win_blit(win_blit), .busy(busy), .bus_ready(bus_ready),
    .op_start(op_start), .op(op)
  );

  raster_seq u_seq (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_in(op),
    .mem_rdata(mem_rdata), .busy(busy), .op_done(op_done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .dirty_valid(dirty_valid),
    .dirty_start(dirty_start), .dirty_len(dirty_len)
  );
endmodule

// File: rtl/raster_engine_chk.sv
module raster_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       bus_ready,
  input logic       mem_we,
  input logic       mem_re,
  input logic       dirty_valid,
  input logic [5:0] dirty_len,
  input logic       op_start,
  input logic       op_done
);
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !busy);
  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy);
  assert_stall_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> busy);
  assert_done_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> dirty_valid && !busy);
  assert_dirty_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |=> !dirty_valid);
  assert_dirty_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> (dirty_len >= 6'd1 && dirty_len <= 6'd32));
  assert_mem_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re);
  assert_rw_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind raster_engine raster_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_ready(bus_ready),
  .mem_we(mem_we), .mem_re(mem_re), .dirty_valid(dirty_valid),
  .dirty_len(dirty_len), .op_start(op_start), .op_done(op_done)
);

// File: tb/raster_engine_test.sv
module raster_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, win_blit = 1'b0;
  logic [22:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, busy, mem_we, mem_re, dirty_valid;
  logic [23:0] mem_addr, dirty_start;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [5:0]  dirty_len;

  always #10 clk = ~clk;

  raster_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .win_blit(win_blit), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .dirty_valid(dirty_valid),
    .dirty_start(dirty_start), .dirty_len(dirty_len)
  );

  function automatic bit [7:0] pat(int a);
    return 8'(a * 13 + 5);
  endfunction

  // pixel memory seen by the design: one-cycle read latency
  bit [7:0] dram[int];
  always @(posedge clk) begin
    if (mem_we) dram[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= dram.exists(int'(mem_addr)) ? dram[int'(mem_addr)] : pat(int'(mem_addr));
  end

  // reference model: per-cycle schedule of expected memory actions
  typedef struct {bit we; bit re; int a; bit [7:0] d;} ent_t;
  ent_t     q[$];
  string    tq[$];
  bit [7:0] mram[int];
  bit [31:0] mcol = '0;
  bit       arm = 0, done = 0;
  int       exp_ds, exp_dl, checks = 0, fails = 0;
  ent_t     e;
  string    t;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [7:0] mrd(int a);
    return mram.exists(a) ? mram[a] : pat(a);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        t = tq.pop_front();
        chk(busy && mem_we == e.we && mem_re == e.re &&
            (!e.we || (mem_addr == 24'(e.a) && mem_wdata == e.d)) &&
            (!e.re || mem_addr == 24'(e.a)),
            t, "pixel step {busy,we,re,addr,data}",
            {busy, mem_we, mem_re, mem_addr, mem_wdata},
            {1'b1, e.we, e.re, 24'(e.a), e.d});
        if (q.size() == 0) arm = 1;
      end else if (arm) begin
        // R10: range report one cycle after the last pixel
        chk(dirty_valid && !busy && dirty_start == 24'(exp_ds) && dirty_len == 6'(exp_dl),
            "R10", "dirty {valid,busy,start,len}",
            {dirty_valid, busy, dirty_start, dirty_len}, {1'b1, 1'b0, 24'(exp_ds), 6'(exp_dl)});
        arm = 0;
      end else begin
        chk(!busy && !mem_we && !mem_re && !dirty_valid, "R9", "idle {busy,we,re,dv}",
            {busy, mem_we, mem_re, dirty_valid}, 4'b0);
      end
    end
  end

  task automatic model_op(bit [22:0] addr, bit [31:0] d, bit blit, string tag);
    int dst = int'(addr[22:3]);
    int n;
    if (!blit) begin
      n = 32;
      for (int i = 0; i < 32; i++) begin
        bit w = d[31-i];
        q.push_back('{w, 1'b0, (dst + i) & 'hFFFFFF, mcol[7:0]}); tq.push_back(tag);
        if (w) mram[(dst + i) & 'hFFFFFF] = mcol[7:0];
      end
    end else begin
      int src = int'(d[23:0]);
      n = int'(d[28:24]) + 1;
      for (int i = 0; i < n; i++) begin
        int da = (dst + i) & 'hFFFFFF;
        if (src == 'hFFFFFF) begin
          q.push_back('{1'b1, 1'b0, da, mcol[7:0]}); tq.push_back(tag);
          mram[da] = mcol[7:0];
        end else begin
          int sa = (src + i) & 'hFFFFFF;
          bit [7:0] v = mrd(sa);
          q.push_back('{1'b0, 1'b1, sa, 8'h0}); tq.push_back(tag);
          q.push_back('{1'b1, 1'b0, da, v});    tq.push_back(tag);
          mram[da] = v;
        end
      end
    end
    exp_ds = dst;
    exp_dl = n;
  endtask

  task automatic bus_write(bit [22:0] addr, bit [31:0] d, bit [3:0] be, bit blit,
                           string tag, output int stalls);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = addr; bus_wdata = d; bus_be = be; win_blit = blit;
    stalls = 0;
    #1;
    while (!bus_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    if (be == 4'hF) begin
      if (addr[2]) model_op(addr, d, blit, tag);
      else mcol = d;
    end
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0; bus_be = 0;
  endtask

  task automatic bus_read(bit [22:0] addr, bit blit, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = addr; bus_be = 4'hF; win_blit = blit;
    #1;
    chk(bus_rdata == 32'h0, tag, "read data", bus_rdata, 0);
    @(posedge clk);
    #1;
    bus_sel = 0; bus_be = 0;
  endtask

  task automatic wait_done();
    do begin
      @(negedge clk);
      #1;
    end while (q.size() != 0 || arm);
  endtask

  function automatic bit [22:0] trig(int dst, bit [2:0] low);
    return {20'(dst), low};
  endfunction

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_up();
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    chk(!busy && !dirty_valid && !mem_we && !mem_re && bus_ready, "R11", "reset outputs",
        {busy, dirty_valid, mem_we, mem_re, bus_ready}, 5'b00001);

    // R1 + R3: colour latch, then stipple end bits
    bus_write(23'h0, 32'h123456AB, 4'hF, 0, "R1", st);
    bus_write(trig('h100, 3'b100), 32'h80000001, 4'hF, 0, "R3", st);
    wait_done();
    // R2: destination from address bits 22:3, low bits ignored
    bus_write(trig('hFFFF0, 3'b111), 32'hA5F00F5A, 4'hF, 0, "R2", st);
    wait_done();
    // R5: fill of 10 pixels
    bus_write(23'h0, 32'h000000CD, 4'hF, 1, "R1", st);
    bus_write(trig('h200, 3'b100), {3'b0, 5'd9, 24'hFFFFFF}, 4'hF, 1, "R5", st);
    wait_done();
    // R4: longest and shortest runs
    bus_write(trig('h240, 3'b100), 32'h1FFFFFFF, 4'hF, 1, "R4", st);
    wait_done();
    bus_write(trig('h280, 3'b100), 32'hE0FFFFFF, 4'hF, 1, "R4", st);
    wait_done();
    // R6: plain copy, then forward overlapping copy
    bus_write(trig('h300, 3'b100), {3'b0, 5'd7, 24'h001000}, 4'hF, 1, "R6", st);
    wait_done();
    bus_write(trig('h301, 3'b100), {3'b0, 5'd4, 24'h000300}, 4'hF, 1, "R6", st);
    wait_done();
    // R7: reads return zero in both windows
    bus_read(23'h4, 0, "R7");
    bus_read(23'h4, 1, "R7");
    bus_read(23'h0, 1, "R7");
    // R8: partial trigger and partial colour write are ignored
    bus_write(trig('h400, 3'b100), 32'hFFFFFFFF, 4'h3, 0, "R8", st);
    bus_write(23'h0, 32'h000000EE, 4'h1, 0, "R8", st);
    bus_write(trig('h400, 3'b100), 32'hFFFFFFFF, 4'hF, 0, "R8", st);
    wait_done();
    // R9: colour write during a fill is accepted, trigger is held
    bus_write(23'h0, 32'h00000011, 4'hF, 1, "R1", st);
    bus_write(trig('h500, 3'b100), 32'h1FFFFFFF, 4'hF, 1, "R9", st);
    bus_write(23'h0, 32'h00000077, 4'hF, 0, "R9", st);
    chk(st == 0, "R9", "colour write stalls", st, 0);
    bus_write(trig('h600, 3'b100), 32'hF0F0F0F0, 4'hF, 0, "R9", st);
    chk(st > 0, "R9", "trigger while busy stalled", st, 1);
    wait_done();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule